// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block loads a read-retry mode into the private tuning registers of a multi-level-cell NAND flash device. It does this by producing a stream of byte beats for a raw NAND physical layer. Each beat is tagged as a command, an address or a data byte, or as a page-read request. The physical layer turns each beat into the matching bus cycle with the right timing. The sequencer only decides which bytes go out and in what order.

For a retry load, the caller pulses `start_retry` with a mode index. The block then sends the parameter-entry opcode. For each tuning register it sends the register address twice, once as each column byte, followed by the value for that register. The value comes from an external mode table through a combinational lookup port. The block closes the stream with the apply opcode.

A second entry point, `start_otp`, runs a fixed preamble. That preamble unlocks the one-time-programmable area that holds the factory retry values and reads the page that contains them. It then restores normal operation. The block reports progress through a busy level and a one-cycle done pulse. It keeps a sticky error flag for requests it refused.

Top module: `nand_retry_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `bus_valid` are all 0.
- R2: A retry load sends its beats in this order. First comes CMD 0x36. Then, for each register in the order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF, the block sends ADDR(reg), ADDR(reg), DATA(value). Last comes CMD 0x16. The `bus_kind` encoding is 0 = command, 1 = address, 2 = data, 3 = page read.
- R3: During the data beat for register number r (counting from 0) of mode m, `tbl_addr` equals m*8 + r, and `bus_byte` equals `tbl_data`. The table must stay stable while a load runs.
- R4: An OTP run sends these beats in order: CMD 0xFF (reset), CMD 0x36, ADDR 0x38, ADDR 0x38, DATA 0x52, CMD 0x16, CMD 0x17, CMD 0x04, CMD 0x19, READ of page `OTP_PAGE` (default 0x20), CMD 0xFF, CMD 0x36, ADDR 0x38, ADDR 0x38, DATA 0x00, CMD 0x16, and finally READ of page 0x00.
- R5: Output stream rules:
  - The stream advances only on a cycle where `bus_valid` and `bus_ready` are both high.
  - While `bus_valid` is high and `bus_ready` is low, `bus_valid` and `bus_kind` hold their values in the next cycle.
  - `bus_byte` also holds, except on data beats of a retry load, which follow the table.
  - The block applies back-pressure only by keeping the beat on offer.
- R6: In the cycle after the last beat is accepted, `done` is 1 for exactly one cycle and `busy` is 0.
- R7: A start pulse that arrives while `busy` is high does not change the running stream. The error flag reads 1 in the next cycle.
- R8: A retry start whose mode index is at or above `NMODES` (default 7) raises the error flag in the next cycle. No beat is offered, and `busy` stays 0.
- R9: The error flag stays set until a start is accepted. An accepted start clears it in the next cycle.
- R10: If `start_retry` and `start_otp` arrive in the same idle cycle, the retry request wins and the OTP request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_retry | input | 1 | Pulse to load the retry mode given on `mode_idx` |
| start_otp | input | 1 | Pulse to run the OTP read preamble and restore |
| mode_idx | input | MODE_W | Retry mode index, sampled with `start_retry` |
| tbl_addr | output | TBL_W | Flat index into the external mode table |
| tbl_data | input | 8 | Table value at `tbl_addr`, combinational |
| bus_valid | output | 1 | A beat is on offer to the physical layer |
| bus_ready | input | 1 | The physical layer takes the beat this cycle |
| bus_kind | output | 2 | Beat type: 0 command, 1 address, 2 data, 3 page read |
| bus_byte | output | 8 | Opcode, column byte, data byte or page address |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the final beat is accepted |
| err | output | 1 | Sticky flag for a refused request |

## Verification
All outputs come from registers, so every result is due one clock after the edge that caused it:
- After an accepted start edge, the first beat and `busy` appear in the next cycle.
- After the edge that accepts a beat, the following beat appears in the next cycle.
- After the edge that takes the last beat, the `done` pulse appears in the next cycle.
- After a refused start, the error flag appears in the next cycle.

The bench drives inputs and sets `bus_ready` on the falling edge. It samples one time unit later, so every comparison falls inside the cycle in which its result is due. During stalls it compares the held beat with the previous cycle's beat, which checks the back-pressure rule in that same cycle.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DATA = 2'd2,
    K_READ = 2'd3
  } beat_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ENTER,
    S_ADDR_HI,
    S_ADDR_LO,
    S_DATA,
    S_APPLY,
    S_OTP
  } seq_state_e;

  typedef struct packed {
    beat_kind_e kind;
    logic [7:0] data;
  } beat_t;

  localparam logic [7:0] OP_ENTER   = 8'h36;
  localparam logic [7:0] OP_APPLY   = 8'h16;
  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_UNLK_A  = 8'h17;
  localparam logic [7:0] OP_UNLK_B  = 8'h04;
  localparam logic [7:0] OP_UNLK_C  = 8'h19;
  localparam logic [7:0] OTP_CTL_RG = 8'h38;
  localparam logic [7:0] OTP_CTL_ON = 8'h52;
  localparam int unsigned OTP_STEPS = 17;
  localparam int unsigned OTP_SW    = $clog2(OTP_STEPS);

  // Private tuning register addresses, in load order.
  function automatic logic [7:0] retry_reg_addr(input int unsigned idx);
    case (idx)
      0:       retry_reg_addr = 8'hCC;
      1:       retry_reg_addr = 8'hBF;
      2:       retry_reg_addr = 8'hAA;
      3:       retry_reg_addr = 8'hAB;
      4:       retry_reg_addr = 8'hCD;
      5:       retry_reg_addr = 8'hAD;
      6:       retry_reg_addr = 8'hAE;
      7:       retry_reg_addr = 8'hAF;
      default: retry_reg_addr = 8'h00;
    endcase
  endfunction

  // Fixed unlock / read / restore chain.
  function automatic beat_t otp_beat(input logic [OTP_SW-1:0] step,
                                     input logic [7:0] page);
    beat_t b;
    case (step)
      5'd0:    b = '{K_CMD,  OP_RESET};
      5'd1:    b = '{K_CMD,  OP_ENTER};
      5'd2:    b = '{K_ADDR, OTP_CTL_RG};
      5'd3:    b = '{K_ADDR, OTP_CTL_RG};
      5'd4:    b = '{K_DATA, OTP_CTL_ON};
      5'd5:    b = '{K_CMD,  OP_APPLY};
      5'd6:    b = '{K_CMD,  OP_UNLK_A};
      5'd7:    b = '{K_CMD,  OP_UNLK_B};
      5'd8:    b = '{K_CMD,  OP_UNLK_C};
      5'd9:    b = '{K_READ, page};
      5'd10:   b = '{K_CMD,  OP_RESET};
      5'd11:   b = '{K_CMD,  OP_ENTER};
      5'd12:   b = '{K_ADDR, OTP_CTL_RG};
      5'd13:   b = '{K_ADDR, OTP_CTL_RG};
      5'd14:   b = '{K_DATA, 8'h00};
      5'd15:   b = '{K_CMD,  OP_APPLY};
      5'd16:   b = '{K_READ, 8'h00};
      default: b = '{K_CMD,  OP_RESET};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nrr_start_gate.sv
module nrr_start_gate #(
  parameter int unsigned NMODES = 7,
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              start_retry,
  input  logic              start_otp,
  input  logic [MODE_W-1:0] mode_idx,
  output logic              go_retry,
  output logic              go_otp,
  output logic              err
);

  logic mode_ok;
  logic refuse;

  assign mode_ok  = (32'(mode_idx) < NMODES);
  assign go_retry = !busy && start_retry && mode_ok;
  assign go_otp   = !busy && start_otp && !start_retry;
  assign refuse   = (busy && (start_retry || start_otp)) ||
                    (!busy && start_retry && !mode_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err <= 1'b0;
    else if (refuse)              err <= 1'b1;
    else if (go_retry || go_otp)  err <= 1'b0;
  end

endmodule

// File: rtl/nrr_ctrl.sv
module nrr_ctrl
  import nrr_pkg::*;
#(
  parameter int unsigned NREGS  = 8,
  parameter int unsigned MODE_W = 4,
  localparam int unsigned REG_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_retry,
  input  logic              go_otp,
  input  logic [MODE_W-1:0] mode_idx,
  input  logic              fire,
  output seq_state_e        state,
  output logic [REG_W-1:0]  reg_idx,
  output logic [OTP_SW-1:0] otp_step,
  output logic [MODE_W-1:0] mode_q,
  output logic              done
);

  localparam logic [REG_W-1:0]  REG_LAST = REG_W'(NREGS - 1);
  localparam logic [OTP_SW-1:0] OTP_LAST = OTP_SW'(OTP_STEPS - 1);

  seq_state_e        state_n;
  logic [REG_W-1:0]  reg_n;
  logic [OTP_SW-1:0] step_n;
  logic              done_n;

  always_comb begin
    state_n = state;
    reg_n   = reg_idx;
    step_n  = otp_step;
    done_n  = 1'b0;
    case (state)
      S_IDLE: begin
        if (go_retry) begin
          state_n = S_ENTER;
          reg_n   = '0;
        end else if (go_otp) begin
          state_n = S_OTP;
          step_n  = '0;
        end
      end
      S_ENTER:   if (fire) state_n = S_ADDR_HI;
      S_ADDR_HI: if (fire) state_n = S_ADDR_LO;
      S_ADDR_LO: if (fire) state_n = S_DATA;
      S_DATA: begin
        if (fire) begin
          if (reg_idx == REG_LAST) begin
            state_n = S_APPLY;
          end else begin
            state_n = S_ADDR_HI;
            reg_n   = reg_idx + 1'b1;
          end
        end
      end
      S_APPLY: begin
        if (fire) begin
          state_n = S_IDLE;
          done_n  = 1'b1;
        end
      end
      S_OTP: begin
        if (fire) begin
          if (otp_step == OTP_LAST) begin
            state_n = S_IDLE;
            done_n  = 1'b1;
          end else begin
            step_n = otp_step + 1'b1;
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      reg_idx  <= '0;
      otp_step <= '0;
      mode_q   <= '0;
      done     <= 1'b0;
    end else begin
      state    <= state_n;
      reg_idx  <= reg_n;
      otp_step <= step_n;
      done     <= done_n;
      if (state == S_IDLE && go_retry) mode_q <= mode_idx;
    end
  end

endmodule

// File: rtl/nrr_beat_gen.sv
module nrr_beat_gen
  import nrr_pkg::*;
#(
  parameter int unsigned NMODES   = 7,
  parameter int unsigned NREGS    = 8,
  parameter int unsigned MODE_W   = 4,
  parameter logic [7:0]  OTP_PAGE = 8'h20,
  localparam int unsigned REG_W   = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int unsigned TBL_W   = $clog2(NMODES * NREGS)
) (
  input  seq_state_e        state,
  input  logic [REG_W-1:0]  reg_idx,
  input  logic [OTP_SW-1:0] otp_step,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [7:0]        tbl_data,
  output logic [TBL_W-1:0]  tbl_addr,
  output beat_t             beat
);

  logic [7:0] reg_addr;

  assign tbl_addr = TBL_W'(mode_q) * TBL_W'(NREGS) + TBL_W'(reg_idx);
  assign reg_addr = retry_reg_addr(32'(reg_idx));

  always_comb begin
    case (state)
      S_ENTER:   beat = '{K_CMD,  OP_ENTER};
      S_ADDR_HI: beat = '{K_ADDR, reg_addr};
      S_ADDR_LO: beat = '{K_ADDR, reg_addr};
      S_DATA:    beat = '{K_DATA, tbl_data};
      S_APPLY:   beat = '{K_CMD,  OP_APPLY};
      S_OTP:     beat = otp_beat(otp_step, OTP_PAGE);
      default:   beat = '{K_CMD,  8'h00};
    endcase
  end

endmodule

// File: rtl/nand_retry_seq.sv
module nand_retry_seq
  import nrr_pkg::*;
#(
  parameter int unsigned NMODES   = 7,
  parameter int unsigned NREGS    = 8,
  parameter int unsigned MODE_W   = 4,
  parameter logic [7:0]  OTP_PAGE = 8'h20,
  localparam int unsigned REG_W   = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int unsigned TBL_W   = $clog2(NMODES * NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_retry,
  input  logic              start_otp,
  input  logic [MODE_W-1:0] mode_idx,
  output logic [TBL_W-1:0]  tbl_addr,
  input  logic [7:0]        tbl_data,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [1:0]        bus_kind,
  output logic [7:0]        bus_byte,
  output logic              busy,
  output logic              done,
  output logic              err
);

  seq_state_e        state;
  logic [REG_W-1:0]  reg_idx;
  logic [OTP_SW-1:0] otp_step;
  logic [MODE_W-1:0] mode_q;
  logic              go_retry;
  logic              go_otp;
  logic              fire;
  beat_t             beat;

  assign busy      = (state != S_IDLE);
  assign bus_valid = busy;
  assign fire      = bus_valid && bus_ready;
  assign bus_kind  = beat.kind;
  assign bus_byte  = beat.data;

  nrr_start_gate #(.NMODES(NMODES), .MODE_W(MODE_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .start_retry (start_retry),
    .start_otp   (start_otp),
    .mode_idx    (mode_idx),
    .go_retry    (go_retry),
    .go_otp      (go_otp),
    .err         (err)
  );

  nrr_ctrl #(.NREGS(NREGS), .MODE_W(MODE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_retry (go_retry),
    .go_otp   (go_otp),
    .mode_idx (mode_idx),
    .fire     (fire),
    .state    (state),
    .reg_idx  (reg_idx),
    .otp_step (otp_step),
    .mode_q   (mode_q),
    .done     (done)
  );

  nrr_beat_gen #(
    .NMODES(NMODES), .NREGS(NREGS), .MODE_W(MODE_W), .OTP_PAGE(OTP_PAGE)
  ) u_beat (
    .state    (state),
    .reg_idx  (reg_idx),
    .otp_step (otp_step),
    .mode_q   (mode_q),
    .tbl_data (tbl_data),
    .tbl_addr (tbl_addr),
    .beat     (beat)
  );

endmodule

// File: rtl/nrr_checker.sv
module nrr_checker #(
  parameter int unsigned NMODES = 7,
  parameter int unsigned MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_retry,
  input logic              start_otp,
  input logic [MODE_W-1:0] mode_idx,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [1:0]        bus_kind,
  input logic [7:0]        bus_byte,
  input logic              busy,
  input logic              done,
  input logic              err
);

  AST_HOLD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_kind)); // R5

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && bus_kind != 2'd2 |=> $stable(bus_byte)); // R5

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !bus_valid); // R6

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (start_retry || start_otp) |=> err); // R7

  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_retry && (32'(mode_idx) >= NMODES) |=> err && !bus_valid); // R8

  AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_otp && !start_retry |=> !err && busy); // R9

endmodule

bind nand_retry_seq nrr_checker #(.NMODES(NMODES), .MODE_W(MODE_W)) u_nrr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_retry (start_retry),
  .start_otp   (start_otp),
  .mode_idx    (mode_idx),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .bus_kind    (bus_kind),
  .bus_byte    (bus_byte),
  .busy        (busy),
  .done        (done),
  .err         (err)
);

// File: tb/tb_nand_retry_seq.sv
module tb_nand_retry_seq;

  localparam int CLK_P  = 10;
  localparam int NMODES = 7;
  localparam int MODE_W = 4;
  localparam int TBL_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_retry = 1'b0;
  logic              start_otp = 1'b0;
  logic [MODE_W-1:0] mode_idx = '0;
  logic [TBL_W-1:0]  tbl_addr;
  logic [7:0]        tbl_data;
  logic              bus_valid;
  logic              bus_ready = 1'b0;
  logic [1:0]        bus_kind;
  logic [7:0]        bus_byte;
  logic              busy, done, err;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  // External mode table: value depends on the flat index only.
  assign tbl_data = 8'(32'(tbl_addr) * 29 + 7);

  nand_retry_seq dut (
    .clk(clk), .rst_n(rst_n), .start_retry(start_retry), .start_otp(start_otp),
    .mode_idx(mode_idx), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_kind(bus_kind),
    .bus_byte(bus_byte), .busy(busy), .done(done), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input int r);
    case (r)
      0: return 8'hCC; 1: return 8'hBF; 2: return 8'hAA; 3: return 8'hAB;
      4: return 8'hCD; 5: return 8'hAD; 6: return 8'hAE; default: return 8'hAF;
    endcase
  endfunction

  // Expected beat {kind, byte} number n of a sequence.
  function automatic logic [9:0] exp_beat(input bit otp, input int mode, input int n);
    if (!otp) begin
      if (n == 0)  return {2'd0, 8'h36};
      if (n == 25) return {2'd0, 8'h16};
      if ((n - 1) % 3 < 2) return {2'd1, reg_of((n - 1) / 3)};
      return {2'd2, 8'((mode * 8 + (n - 1) / 3) * 29 + 7)};
    end
    case (n)
      0: return {2'd0, 8'hFF};  1: return {2'd0, 8'h36};
      2: return {2'd1, 8'h38};  3: return {2'd1, 8'h38};
      4: return {2'd2, 8'h52};  5: return {2'd0, 8'h16};
      6: return {2'd0, 8'h17};  7: return {2'd0, 8'h04};
      8: return {2'd0, 8'h19};  9: return {2'd3, 8'h20};
      10: return {2'd0, 8'hFF}; 11: return {2'd0, 8'h36};
      12: return {2'd1, 8'h38}; 13: return {2'd1, 8'h38};
      14: return {2'd2, 8'h00}; 15: return {2'd0, 8'h16};
      default: return {2'd3, 8'h00};
    endcase
  endfunction

  // Runs one sequence starting at a falling edge.
  task automatic run_seq(input bit otp, input int mode, input int stall,
                         input int poke, input bit both);
    int len = otp ? 17 : 26;
    int n = 0;
    int cyc = 0;
    bit held = 0;
    logic [9:0] saved = '0;
    start_retry = !otp || both;
    start_otp   = otp || both;
    mode_idx    = MODE_W'(mode);
    @(negedge clk);
    start_retry = 0;
    start_otp   = 0;
    #1;
    check("R9 err cleared by accepted start", 32'(err), 0);
    check("R6 busy after start", 32'(busy), 1);
    while (n < len && cyc < 400) begin
      bus_ready = ((cyc % (stall + 1)) == 0);
      if (cyc == poke) start_otp = 1;
      if (cyc == poke + 1) check("R7 err after busy start", 32'(err), 1);
      #1;
      if (held) check("R5 beat held under stall", {22'd0, bus_kind, bus_byte}, {22'd0, saved});
      check("R5 valid while running", 32'(bus_valid), 1);
      if (bus_ready) begin
        check(otp ? "R4 otp beat" : (bus_kind == 2'd2 ? "R3 table data" : "R2 retry beat"),
              {22'd0, bus_kind, bus_byte}, {22'd0, exp_beat(otp, mode, n)});
        if (!otp && bus_kind == 2'd2)
          check("R3 table index", 32'(tbl_addr), 32'(mode * 8 + (n - 1) / 3));
        n++;
        held = 0;
      end else begin
        saved = {bus_kind, bus_byte};
        held = 1;
      end
      @(negedge clk);
      start_otp = 0;
      cyc++;
    end
    bus_ready = 0;
    #1;
    check("R6 done after last beat", 32'(done), 1);
    check("R6 idle after last beat", 32'(busy), 0);
    @(negedge clk);
    #1;
    check("R6 done is one cycle", 32'(done), 0);
  endtask

  // {otp, mode[3:0], stall[2:0]}
  localparam logic [7:0] VEC [6] = '{
    {1'b0, 4'd0, 3'd0}, {1'b0, 4'd3, 3'd1}, {1'b0, 4'd6, 3'd2},
    {1'b1, 4'd0, 3'd0}, {1'b1, 4'd0, 3'd3}, {1'b0, 4'd5, 3'd0}
  };

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy at reset", 32'(busy), 0);
    check("R1 done at reset", 32'(done), 0);
    check("R1 err at reset", 32'(err), 0);
    check("R1 valid at reset", 32'(bus_valid), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 6; i++)
      run_seq(VEC[i][7], int'(VEC[i][6:3]), int'(VEC[i][2:0]), -10, 0);

    // R7: OTP start pulsed mid-stream; retry stream must stay intact.
    run_seq(0, 2, 1, 7, 0);
    check("R9 err holds after sequence", 32'(err), 1);

    // R8: out-of-range mode.
    run_seq(1, 0, 0, -10, 0);
    start_retry = 1;
    mode_idx = MODE_W'(NMODES);
    @(negedge clk);
    start_retry = 0;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R8 no beat for bad mode", 32'(bus_valid), 0);
      check("R8 stays idle", 32'(busy), 0);
      check("R8 err raised", 32'(err), 1);
      @(negedge clk);
    end

    // R10: both starts together, retry wins.
    run_seq(0, 4, 0, -10, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule